// File: doc/BRIEF.md
# Overlay Key and Transparency Aligner

This block decides, pixel by pixel, whether locally drawn graphics or an external video source should be visible, and produces a matching 6-bit transparency code. For each pixel it receives the 12-bit RGB colour (4 bits per channel), the current border colour, a flag that marks the pixel as background colour, and the pixel's own transparency code. A small bank of configuration registers, loaded through a write strobe, sets the key mode, the chroma-key colour, a fallback polarity, the transparency enable, the background transparency value and the output delay.

The overlay switch `ys_o` is high where graphics must show and low where the external picture must show through. Both `ys_o` and `trans_o` pass through an 8-stage shift register clocked by the 4x subcarrier clock. A 3-bit phase value selects the tap, so the outputs can be shifted by 0 to 7 clocks against the composite video path. Tap 4 lines up with that path.

Top module: `ovl_key_gen`

## Requirements
- R1: While `rst_ni` is low, `ys_o` and `trans_o` are 0.
- R2: When `sup_en_i` is low, the key decision is ys=1 (graphics shown everywhere) and the transparency code is 0, whatever the other inputs are.
- R3: In key mode 2'b11 with `sup_en_i` high, ys is 1 when the pixel colour differs from the stored chroma-key colour and 0 when it is equal.
- R4: In key mode 2'b01 with `sup_en_i` high and a border colour other than 12'h000, ys is 1 when the pixel colour differs from the border colour and 0 when it is equal.
- R5: In key mode 2'b01 with a border colour of 12'h000, ys equals the fallback bit, and the pixel colour has no effect.
- R6: In key modes 2'b00 and 2'b10, ys equals the fallback bit, and the pixel, border and chroma-key colours have no effect.
- R7: With `sup_en_i` high and the transparency enable at 0, the transparency code is 6'h00.
- R8: With `sup_en_i` high and the transparency enable at 1, the transparency code is the stored background value when `pix_bg_i` is 1, and `pix_trans_i` when `pix_bg_i` is 0.
- R9: For an input sampled at clock edge e, the result shows on `ys_o`/`trans_o` right after edge e+P, where P is the stored phase value (0..7).
- R10: The configuration registers take the `cfg_*_i` values only on an edge where `cfg_wr_i` is 1. At other times they hold their value.
- R11: After reset the configuration is: phase 1, key mode 2'b00, fallback 0, chroma key 12'h000, transparency enable 1, background transparency 6'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 4x subcarrier clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sup_en_i | input | 1 | Superimpose enable |
| pix_rgb_i | input | 12 | Pixel colour {R,G,B} |
| pix_bg_i | input | 1 | Pixel is background colour |
| pix_trans_i | input | 6 | Pixel transparency code |
| border_rgb_i | input | 12 | Border colour {R,G,B} |
| cfg_wr_i | input | 1 | Configuration load strobe |
| cfg_phase_i | input | 3 | Output delay tap |
| cfg_mode_i | input | 2 | Key mode |
| cfg_fallback_i | input | 1 | Whole-screen polarity when no comparison applies |
| cfg_ckey_i | input | 12 | Chroma-key colour |
| cfg_trans_en_i | input | 1 | Transparency enable |
| cfg_bg_trans_i | input | 6 | Background transparency code |
| ys_o | output | 1 | Overlay switch, delayed |
| trans_o | output | 6 | Transparency code, delayed |

## Verification
The key decision is driven with pixels that equal and then differ from the chroma key, and with pixels that equal and then differ from a non-black border. This shows that a real comparison takes place in each of those two modes. Black-border and no-compare cases use pixels that would have produced the opposite answer had a comparison run, so only the fallback bit can explain the result. The delay is exercised by stepping the decision from one value to another and sampling one edge before and on the expected edge, at taps 0, 4 and 7 and at the reset default. Background and non-background pixels carry different codes, so the transparency selection is visible at the output.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int RGB_W   = 12;
  localparam int TRANS_W = 6;
  localparam int DEPTH   = 8;
  localparam int PHASE_W = $clog2(DEPTH);

  typedef enum logic [1:0] {
    KEY_NONE   = 2'b00,
    KEY_BORDER = 2'b01,
    KEY_RSVD   = 2'b10,
    KEY_CHROMA = 2'b11
  } key_mode_e;

  typedef struct packed {
    logic [PHASE_W-1:0] phase;
    key_mode_e          mode;
    logic               fallback;
    logic [RGB_W-1:0]   ckey;
    logic               trans_en;
    logic [TRANS_W-1:0] bg_trans;
  } cfg_t;

  localparam cfg_t CFG_RST = '{
    phase:    PHASE_W'(1),
    mode:     KEY_NONE,
    fallback: 1'b0,
    ckey:     '0,
    trans_en: 1'b1,
    bg_trans: '0
  };
endpackage

// File: rtl/ovl_cfg_regs.sv
module ovl_cfg_regs
  import ovl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  cfg_t cfg_i,
  output cfg_t cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_o <= CFG_RST;
    else if (wr_i) cfg_o <= cfg_i;
  end
endmodule

// File: rtl/ovl_key_decide.sv
module ovl_key_decide
  import ovl_pkg::*;
(
  input  logic               sup_en_i,
  input  logic [RGB_W-1:0]   pix_rgb_i,
  input  logic               pix_bg_i,
  input  logic [TRANS_W-1:0] pix_trans_i,
  input  logic [RGB_W-1:0]   border_rgb_i,
  input  cfg_t               cfg_i,
  output logic               ys_o,
  output logic [TRANS_W-1:0] trans_o
);
  logic border_black;
  logic cmp_ys;

  assign border_black = (border_rgb_i == '0);

  always_comb begin
    unique case (cfg_i.mode)
      KEY_CHROMA: cmp_ys = (pix_rgb_i != cfg_i.ckey);
      KEY_BORDER: cmp_ys = border_black ? cfg_i.fallback : (pix_rgb_i != border_rgb_i);
      default:    cmp_ys = cfg_i.fallback;  // none and reserved
    endcase
  end

  always_comb begin
    ys_o    = sup_en_i ? cmp_ys : 1'b1;
    trans_o = '0;
    if (sup_en_i && cfg_i.trans_en)
      trans_o = pix_bg_i ? cfg_i.bg_trans : pix_trans_i;
  end
endmodule

// File: rtl/ovl_phase_delay.sv
module ovl_phase_delay #(
  parameter int W     = 7,
  parameter int DEPTH = 8,
  localparam int SEL_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     d_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [W-1:0]     q_o
);
  logic [W-1:0] stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    logic [W-1:0] nxt;
    if (i == 0) begin : g_head
      assign nxt = d_i;
    end else begin : g_tail
      assign nxt = stg[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[i] <= '0;
      else         stg[i] <= nxt;
    end
  end

  assign q_o = stg[sel_i];
endmodule

// File: rtl/ovl_key_gen.sv
module ovl_key_gen
  import ovl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sup_en_i,
  input  logic [RGB_W-1:0]   pix_rgb_i,
  input  logic               pix_bg_i,
  input  logic [TRANS_W-1:0] pix_trans_i,
  input  logic [RGB_W-1:0]   border_rgb_i,
  input  logic               cfg_wr_i,
  input  logic [PHASE_W-1:0] cfg_phase_i,
  input  logic [1:0]         cfg_mode_i,
  input  logic               cfg_fallback_i,
  input  logic [RGB_W-1:0]   cfg_ckey_i,
  input  logic               cfg_trans_en_i,
  input  logic [TRANS_W-1:0] cfg_bg_trans_i,
  output logic               ys_o,
  output logic [TRANS_W-1:0] trans_o
);
  cfg_t               cfg_d, cfg_q;
  logic               dec_ys;
  logic [TRANS_W-1:0] dec_trans;
  logic [TRANS_W:0]   dly_q;

  always_comb begin
    cfg_d.phase    = cfg_phase_i;
    cfg_d.mode     = key_mode_e'(cfg_mode_i);
    cfg_d.fallback = cfg_fallback_i;
    cfg_d.ckey     = cfg_ckey_i;
    cfg_d.trans_en = cfg_trans_en_i;
    cfg_d.bg_trans = cfg_bg_trans_i;
  end

  ovl_cfg_regs u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (cfg_wr_i),
    .cfg_i (cfg_d),
    .cfg_o (cfg_q)
  );

  ovl_key_decide u_dec (
    .sup_en_i    (sup_en_i),
    .pix_rgb_i   (pix_rgb_i),
    .pix_bg_i    (pix_bg_i),
    .pix_trans_i (pix_trans_i),
    .border_rgb_i(border_rgb_i),
    .cfg_i       (cfg_q),
    .ys_o        (dec_ys),
    .trans_o     (dec_trans)
  );

  ovl_phase_delay #(.W(TRANS_W + 1), .DEPTH(DEPTH)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dec_ys, dec_trans}),
    .sel_i (cfg_q.phase),
    .q_o   (dly_q)
  );

  assign {ys_o, trans_o} = dly_q;
endmodule

// File: rtl/ovl_key_gen_chk.sv
module ovl_key_gen_chk
  import ovl_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sup_en_i,
  input logic [RGB_W-1:0]   pix_rgb_i,
  input logic [RGB_W-1:0]   border_rgb_i,
  input logic               cfg_wr_i,
  input cfg_t               cfg_q,
  input logic               dec_ys,
  input logic [TRANS_W-1:0] dec_trans,
  input logic               ys_o,
  input logic [TRANS_W-1:0] trans_o
);
  always_comb begin
    if (rst_ni === 1'b0)
      AST_RESET_OUT: assert (ys_o == 1'b0 && trans_o == '0);  // R1
  end

  AST_OFF_SHOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sup_en_i |-> (dec_ys && dec_trans == '0));  // R2

  AST_CHROMA_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sup_en_i && cfg_q.mode == KEY_CHROMA) |-> (dec_ys == (pix_rgb_i != cfg_q.ckey)));  // R3

  AST_BORDER_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sup_en_i && cfg_q.mode == KEY_BORDER && border_rgb_i != '0)
      |-> (dec_ys == (pix_rgb_i != border_rgb_i)));  // R4

  AST_BLACK_FALLBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sup_en_i && cfg_q.mode == KEY_BORDER && border_rgb_i == '0) |-> (dec_ys == cfg_q.fallback));  // R5

  AST_NOCMP_FALLBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sup_en_i && !cfg_q.mode[0]) |-> (dec_ys == cfg_q.fallback));  // R6

  AST_TRANS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sup_en_i && !cfg_q.trans_en) |-> (dec_trans == '0));  // R7

  AST_TAP0_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && cfg_q.phase == '0) |-> ({ys_o, trans_o} == $past({dec_ys, dec_trans})));  // R9

  AST_TAP1_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 2) && cfg_q.phase == PHASE_W'(1))
      |-> ({ys_o, trans_o} == $past({dec_ys, dec_trans}, 2)));  // R9

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(cfg_wr_i)) |-> $stable(cfg_q));  // R10
endmodule

bind ovl_key_gen ovl_key_gen_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sup_en_i    (sup_en_i),
  .pix_rgb_i   (pix_rgb_i),
  .border_rgb_i(border_rgb_i),
  .cfg_wr_i    (cfg_wr_i),
  .cfg_q       (cfg_q),
  .dec_ys      (dec_ys),
  .dec_trans   (dec_trans),
  .ys_o        (ys_o),
  .trans_o     (trans_o)
);

// File: tb/ovl_key_gen_tb.sv
module ovl_key_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sup_en_i = 1'b0;
  logic [11:0] pix_rgb_i = '0;
  logic        pix_bg_i = 1'b0;
  logic [5:0]  pix_trans_i = '0;
  logic [11:0] border_rgb_i = '0;
  logic        cfg_wr_i = 1'b0;
  logic [2:0]  cfg_phase_i = '0;
  logic [1:0]  cfg_mode_i = '0;
  logic        cfg_fallback_i = 1'b0;
  logic [11:0] cfg_ckey_i = '0;
  logic        cfg_trans_en_i = 1'b0;
  logic [5:0]  cfg_bg_trans_i = '0;
  logic        ys_o;
  logic [5:0]  trans_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  ovl_key_gen u_dut (.*);

  typedef struct packed {
    logic        sup;
    logic [1:0]  mode;
    logic        fb;
    logic [11:0] ckey;
    logic        ten;
    logic [5:0]  bgt;
    logic [11:0] pix;
    logic [11:0] border;
    logic        bg;
    logic [5:0]  ptr;
    logic        eys;
    logic [5:0]  etr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'b11, 1'b0, 12'h0F0, 1'b1, 6'h3F, 12'h123, 12'h00F, 1'b1, 6'h15, 1'b1, 6'h00, 4'd2},  // R2
    '{1'b1, 2'b11, 1'b0, 12'h0F0, 1'b1, 6'h3F, 12'h0F0, 12'h00F, 1'b0, 6'h11, 1'b0, 6'h11, 4'd3},  // R3
    '{1'b1, 2'b11, 1'b0, 12'h0F0, 1'b1, 6'h2A, 12'h0F1, 12'h00F, 1'b1, 6'h11, 1'b1, 6'h2A, 4'd3},  // R3
    '{1'b1, 2'b01, 1'b1, 12'h000, 1'b0, 6'h2A, 12'h00F, 12'h00F, 1'b1, 6'h11, 1'b0, 6'h00, 4'd4},  // R4
    '{1'b1, 2'b01, 1'b0, 12'h000, 1'b0, 6'h2A, 12'hF00, 12'h00F, 1'b0, 6'h11, 1'b1, 6'h00, 4'd4},  // R4
    '{1'b1, 2'b01, 1'b0, 12'h000, 1'b1, 6'h01, 12'hFFF, 12'h000, 1'b1, 6'h11, 1'b0, 6'h01, 4'd5},  // R5
    '{1'b1, 2'b01, 1'b1, 12'h000, 1'b1, 6'h01, 12'h000, 12'h000, 1'b0, 6'h22, 1'b1, 6'h22, 4'd5},  // R5
    '{1'b1, 2'b00, 1'b1, 12'h555, 1'b1, 6'h01, 12'h555, 12'h555, 1'b0, 6'h22, 1'b1, 6'h22, 4'd6},  // R6
    '{1'b1, 2'b00, 1'b0, 12'h555, 1'b1, 6'h01, 12'hABC, 12'h00F, 1'b0, 6'h22, 1'b0, 6'h22, 4'd6},  // R6
    '{1'b1, 2'b10, 1'b1, 12'h777, 1'b1, 6'h01, 12'h777, 12'h777, 1'b0, 6'h22, 1'b1, 6'h22, 4'd6},  // R6
    '{1'b1, 2'b11, 1'b0, 12'h444, 1'b0, 6'h3F, 12'h444, 12'h00F, 1'b1, 6'h15, 1'b0, 6'h00, 4'd7},  // R7
    '{1'b1, 2'b00, 1'b1, 12'h000, 1'b1, 6'h07, 12'h321, 12'h00F, 1'b0, 6'h3C, 1'b1, 6'h3C, 4'd8},  // R8
    '{1'b1, 2'b00, 1'b1, 12'h000, 1'b1, 6'h07, 12'h321, 12'h00F, 1'b1, 6'h3C, 1'b1, 6'h07, 4'd8}   // R8
  };

  task automatic check(input int req, input string what, input logic eys, input logic [5:0] etr);
    n_chk++;
    if (ys_o !== eys || trans_o !== etr) begin
      n_err++;
      $display("FAIL R%0d %s: ys=%b trans=%h expected ys=%b trans=%h",
               req, what, ys_o, trans_o, eys, etr);
    end
  endtask

  task automatic write_cfg(input logic [2:0] ph, input logic [1:0] md, input logic fb,
                           input logic [11:0] ck, input logic te, input logic [5:0] bt);
    @(negedge clk_i);
    cfg_phase_i = ph; cfg_mode_i = md; cfg_fallback_i = fb;
    cfg_ckey_i = ck; cfg_trans_en_i = te; cfg_bg_trans_i = bt;
    cfg_wr_i = 1'b1;
    @(negedge clk_i);
    cfg_wr_i = 1'b0;
  endtask

  // State A: sup off -> ys 1 / trans 0. State B: ys 0 / trans 2A (mode 00, fb 0, bg pixel).
  task automatic delay_step(input int req, input int ph);
    sup_en_i = 1'b0; pix_bg_i = 1'b1;
    repeat (9) @(negedge clk_i);
    sup_en_i = 1'b1;
    for (int k = 1; k <= ph + 1; k++) begin
      @(negedge clk_i);
      if (k == ph) check(req, $sformatf("tap %0d one edge early", ph), 1'b1, 6'h00);
      if (k == ph + 1) check(req, $sformatf("tap %0d on time", ph), 1'b0, 6'h2A);
    end
  endtask

  initial begin
    // R1: outputs during reset
    repeat (3) @(negedge clk_i);
    check(1, "reset outputs", 1'b0, 6'h00);
    pix_trans_i = 6'h05;
    rst_ni = 1'b1;

    // R11: defaults (mode 00, fb 0, trans_en 1, bg_trans 0, phase 1)
    sup_en_i = 1'b1; pix_bg_i = 1'b0; pix_rgb_i = 12'hABC;
    repeat (3) @(negedge clk_i);
    check(11, "default trans_en=1 passes pixel code", 1'b0, 6'h05);
    pix_bg_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check(11, "default bg_trans=0", 1'b0, 6'h00);
    sup_en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    sup_en_i = 1'b1;
    @(negedge clk_i);
    check(11, "default phase 1, one edge early", 1'b1, 6'h00);
    @(negedge clk_i);
    check(11, "default phase 1, on time", 1'b0, 6'h00);

    // Table walk at tap 0
    for (int i = 0; i < NV; i++) begin
      write_cfg(3'd0, VEC[i].mode, VEC[i].fb, VEC[i].ckey, VEC[i].ten, VEC[i].bgt);
      sup_en_i = VEC[i].sup; pix_rgb_i = VEC[i].pix; border_rgb_i = VEC[i].border;
      pix_bg_i = VEC[i].bg; pix_trans_i = VEC[i].ptr;
      @(negedge clk_i);
      check(int'(VEC[i].req), $sformatf("vector %0d", i), VEC[i].eys, VEC[i].etr);
    end

    // R9: delay taps
    border_rgb_i = 12'h00F; pix_rgb_i = 12'h123;
    write_cfg(3'd0, 2'b00, 1'b0, 12'h000, 1'b1, 6'h2A);
    delay_step(9, 0);
    write_cfg(3'd4, 2'b00, 1'b0, 12'h000, 1'b1, 6'h2A);
    delay_step(9, 4);
    write_cfg(3'd7, 2'b00, 1'b0, 12'h000, 1'b1, 6'h2A);
    delay_step(9, 7);

    // R10: no strobe -> config held
    write_cfg(3'd0, 2'b00, 1'b0, 12'h123, 1'b1, 6'h2A);
    @(negedge clk_i);
    cfg_mode_i = 2'b11; cfg_fallback_i = 1'b1; cfg_ckey_i = 12'h000;
    cfg_trans_en_i = 1'b0; cfg_phase_i = 3'd7;
    sup_en_i = 1'b1; pix_bg_i = 1'b1; pix_rgb_i = 12'h123;
    repeat (3) @(negedge clk_i);
    check(10, "unstrobed config ignored", 1'b0, 6'h2A);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog (R1..R11 run incomplete): ys=%b trans=%h expected completion",
               ys_o, trans_o);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule